// File: doc/BRIEF.md
# PCI Slot Hotplug Status Controller

This block keeps the hotplug bookkeeping for one PCI bus of up to 32 slots. Three slot vectors are held in flip-flops: which slots hold a device, which slots have a removal request waiting for firmware, and which slots may be removed at all. Firmware sees them through a small I/O window of 32-bit registers with one bit per slot. A status bit tells firmware that a hotplug event is waiting.

Firmware reads the request vector and then writes the eject register. The block serves only the lowest requested slot of the written value. It then pulses `eject_done` with that slot's one-hot bit so that platform logic can tear the device down. The "inserted" view is not stored. It is computed on each read as presence AND removability, so a stale value cannot survive a migration or a reset.

A platform reset request starts a drain. Each cycle, the lowest waiting request is ejected, until none are left. After that, presence and removability are rebuilt from the `occupied` and `fixed_mask` inputs.

Top module: `slot_hotplug_ctrl`

## Requirements
- R1: A read is accepted only when `io_len`=4 and the byte offset is a multiple of 4. The offsets are 0x00 (inserted view), 0x04 (removal requests), 0x08 (feature set), 0x0C (removability) and 0x10 (event status). The inserted view reads presence AND removability.
- R2: Writes to offsets 0x00, 0x04 and 0x0C leave every register unchanged.
- R3: A read at offset 0x08 returns zero. No feature bits are defined.
- R4: An accepted write of a nonzero value V to offset 0x08 acts only on the lowest set bit of V. It clears that slot's removal request, and `eject_done` carries that one-hot slot bit in the cycle after the write, for one cycle only.
- R5: After an eject, the slot's presence bit is cleared when `fixed_mask` for that slot is 0 and kept when it is 1.
- R6: Removability resets to all ones. A cold-plug strobe on a slot whose `fixed_mask` bit is 1 clears that slot's removability bit.
- R7: A `hot_add` strobe sets presence and a `hot_rm` strobe sets the removal request. Either one sets the event status, which is bit 1 of offset 0x10, one cycle later.
- R8: A `cold_add` strobe sets presence and does not raise the event status.
- R9: The event status stays set until an accepted write to offset 0x10 has bit 1 = 1. A write with bit 1 = 0 leaves it set.
- R10: A `plat_rst` pulse starts a drain. Each following cycle, the lowest waiting request is ejected and pulsed on `eject_done`, until none remain. The next cycle loads presence from `occupied` and removability from ~(`fixed_mask` & `occupied`). While the drain runs, event strobes and writes are ignored.
- R11: A write of zero to offset 0x08 changes nothing, and `eject_done` stays zero.
- R12: When an event strobe and an eject hit the same slot in the same cycle, the bits set by the event win over the eject's clears.
- R13: An access with `io_len`≠4 or with a misaligned offset is ignored. A rejected read returns zero.
- R14: After `rst_n` the block holds no presence, no requests, removability all ones, event status 0 and `eject_done` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| plat_rst | input | 1 | Pulse that starts the drain and rebuild |
| cold_add | input | NSLOTS | Per-slot strobes for devices present at boot |
| hot_add | input | NSLOTS | Per-slot hot insertion strobes |
| hot_rm | input | NSLOTS | Per-slot hot removal request strobes |
| fixed_mask | input | NSLOTS | Slots whose occupant cannot be hot-removed |
| occupied | input | NSLOTS | Slots with an attached device, sampled at rebuild |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_addr | input | 5 | Byte offset in the register window |
| io_len | input | 3 | Access size in bytes |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, combinational |
| evt_sts | output | 1 | Hotplug event pending |
| eject_done | output | NSLOTS | One-cycle one-hot pulse naming the slot to be freed |

## Verification
If the presence or removability state is wrong, it shows up on the very next read of the inserted view or the removability register. A wrong request vector shows up on a read at offset 0x04, and again on the `eject_done` pulse one cycle after an eject. The drain order can be checked from the outside, because each cycle of the drain shows its slot on `eject_done`. A bad rebuild shows up in the first read after the drain ends. The event flag is a port, so a dropped set or an early clear can be seen one cycle after the event strobe or the clearing write.

// File: rtl/slot_hotplug_ctrl.sv
module slot_hotplug_ctrl #(
  parameter int NSLOTS = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              plat_rst,
  input  logic [NSLOTS-1:0] cold_add,
  input  logic [NSLOTS-1:0] hot_add,
  input  logic [NSLOTS-1:0] hot_rm,
  input  logic [NSLOTS-1:0] fixed_mask,
  input  logic [NSLOTS-1:0] occupied,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [4:0]        io_addr,
  input  logic [2:0]        io_len,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              evt_sts,
  output logic [NSLOTS-1:0] eject_done
);
  localparam logic [4:0] OFF_UP  = 5'h00;
  localparam logic [4:0] OFF_DN  = 5'h04;
  localparam logic [4:0] OFF_EJ  = 5'h08;
  localparam logic [4:0] OFF_RMV = 5'h0C;
  localparam logic [4:0] OFF_EVT = 5'h10;

  logic [NSLOTS-1:0] pres, down, hp_en;
  logic              drn;

  logic [NSLOTS-1:0] pres_n, down_n, hp_en_n, ej_n;
  logic              evt_n, drn_n;

  wire acc_ok = (io_len == 3'd4) && (io_addr[1:0] == 2'b00);
  wire wr_ok  = io_wr && acc_ok && !drn;
  wire rd_ok  = io_rd && acc_ok;

  wire [NSLOTS-1:0] ej_val = (wr_ok && io_addr == OFF_EJ) ? io_wdata[NSLOTS-1:0] : '0;
  wire [NSLOTS-1:0] ej_bit = ej_val & (~ej_val + 1'b1);
  wire [NSLOTS-1:0] dr_bit = down & (~down + 1'b1);
  wire              evt_clr = wr_ok && io_addr == OFF_EVT && io_wdata[1];
  wire [NSLOTS-1:0] up_view = pres & hp_en;

  always_comb begin
    pres_n  = pres;
    down_n  = down;
    hp_en_n = hp_en;
    ej_n    = '0;
    evt_n   = evt_sts;
    drn_n   = drn;
    if (drn) begin
      if (|down) begin
        down_n = down & ~dr_bit;
        pres_n = pres & ~(dr_bit & ~fixed_mask);
        ej_n   = dr_bit;
      end else begin
        pres_n  = occupied;
        hp_en_n = ~(fixed_mask & occupied);
        drn_n   = 1'b0;
      end
    end else begin
      pres_n  = (pres & ~(ej_bit & ~fixed_mask)) | hot_add | cold_add;
      down_n  = (down & ~ej_bit) | hot_rm;
      hp_en_n = hp_en & ~(cold_add & fixed_mask);
      ej_n    = ej_bit;
      evt_n   = (evt_sts & ~evt_clr) | (|(hot_add | hot_rm));
      if (plat_rst) drn_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres       <= '0;
      down       <= '0;
      hp_en      <= '1;
      evt_sts    <= 1'b0;
      eject_done <= '0;
      drn        <= 1'b0;
    end else begin
      pres       <= pres_n;
      down       <= down_n;
      hp_en      <= hp_en_n;
      evt_sts    <= evt_n;
      eject_done <= ej_n;
      drn        <= drn_n;
    end
  end

  always_comb begin
    io_rdata = '0;
    if (rd_ok) begin
      case (io_addr)
        OFF_UP:  io_rdata = DATA_W'(up_view);
        OFF_DN:  io_rdata = DATA_W'(down);
        OFF_EJ:  io_rdata = '0;
        OFF_RMV: io_rdata = DATA_W'(hp_en);
        OFF_EVT: io_rdata = DATA_W'({evt_sts, 1'b0});
        default: io_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/slot_hotplug_sva.sv
module slot_hotplug_sva #(
  parameter int NSLOTS = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              drn,
  input logic [NSLOTS-1:0] hot_add,
  input logic [NSLOTS-1:0] hot_rm,
  input logic              io_wr,
  input logic              io_rd,
  input logic [4:0]        io_addr,
  input logic [2:0]        io_len,
  input logic [DATA_W-1:0] io_wdata,
  input logic [DATA_W-1:0] io_rdata,
  input logic              evt_sts,
  input logic [NSLOTS-1:0] eject_done
);
  wire clr_wr = io_wr && io_addr == 5'h10 && io_len == 3'd4 && io_wdata[1];

  a_r4_eject_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eject_done));

  a_r7_event_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (!drn && (|(hot_add | hot_rm))) |=> evt_sts);

  a_r9_event_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_sts && !clr_wr) |=> evt_sts);

  a_r11_zero_eject: assert property (@(posedge clk) disable iff (!rst_n)
    (!drn && io_wr && io_addr == 5'h08 && io_len == 3'd4 && io_wdata == '0)
      |=> (eject_done == '0));

  a_r13_bad_len_read: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_len != 3'd4) |-> (io_rdata == '0));

  a_r3_features_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == 5'h08) |-> (io_rdata == '0));
endmodule

bind slot_hotplug_ctrl slot_hotplug_sva #(.NSLOTS(NSLOTS), .DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .drn(drn), .hot_add(hot_add), .hot_rm(hot_rm),
  .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_len(io_len),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .evt_sts(evt_sts),
  .eject_done(eject_done)
);

// File: tb/test_slot_hotplug_ctrl.sv
module test_slot_hotplug_ctrl;
  localparam int N = 32;
  logic clk = 1'b0, rst_n = 1'b0, plat_rst = 1'b0;
  logic [N-1:0] cold_add = '0, hot_add = '0, hot_rm = '0;
  logic [N-1:0] fixed_mask = 32'h0000_0420, occupied = 32'h0000_0421;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [4:0] io_addr = '0;
  logic [2:0] io_len = 3'd4;
  logic [31:0] io_wdata = '0, io_rdata;
  logic evt_sts;
  logic [N-1:0] eject_done;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  slot_hotplug_ctrl i_slot_hotplug_ctrl (
    .clk(clk), .rst_n(rst_n), .plat_rst(plat_rst), .cold_add(cold_add),
    .hot_add(hot_add), .hot_rm(hot_rm), .fixed_mask(fixed_mask),
    .occupied(occupied), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_len(io_len), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .evt_sts(evt_sts), .eject_done(eject_done)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, input logic [2:0] len, output logic [31:0] v);
    io_rd = 1'b1; io_addr = a; io_len = len;
    #1 v = io_rdata;
    io_rd = 1'b0; io_len = 3'd4;
  endtask

  task automatic chk_rd(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, 3'd4, v);
    chk(tag, v, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [2:0] len);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d; io_len = len;
    @(negedge clk);
    io_wr = 1'b0; io_len = 3'd4;
  endtask

  task automatic strobe(input logic [N-1:0] c, input logic [N-1:0] ha, input logic [N-1:0] hr);
    @(negedge clk);
    cold_add = c; hot_add = ha; hot_rm = hr;
    @(negedge clk);
    cold_add = '0; hot_add = '0; hot_rm = '0;
  endtask

  task automatic t_reset;
    chk_rd("R14 up", 5'h00, 32'h0);
    chk_rd("R14 down", 5'h04, 32'h0);
    chk_rd("R14 rmv", 5'h0C, 32'hffff_ffff);
    chk_rd("R3 features", 5'h08, 32'h0);
    chk("R14 evt", 32'(evt_sts), 32'h0);
    chk("R14 eject_done", eject_done, 32'h0);
  endtask

  task automatic t_cold;
    strobe(32'h28, '0, '0);
    chk_rd("R1 up view", 5'h00, 32'h08);
    chk_rd("R6 rmv after fixed cold add", 5'h0C, 32'hffff_ffdf);
    chk("R8 no event", 32'(evt_sts), 32'h0);
  endtask

  task automatic t_hot;
    strobe('0, 32'h80, '0);
    chk_rd("R7 up after hot add", 5'h00, 32'h88);
    chk("R7 evt set", 32'(evt_sts), 32'h1);
    wr(5'h10, 32'h1, 3'd4);
    chk("R9 evt held on bit1=0", 32'(evt_sts), 32'h1);
    chk_rd("R1 evt reg", 5'h10, 32'h2);
    wr(5'h10, 32'h2, 3'd4);
    chk("R9 evt cleared", 32'(evt_sts), 32'h0);
    strobe('0, '0, 32'h88);
    chk_rd("R7 down", 5'h04, 32'h88);
    chk("R7 evt on removal", 32'(evt_sts), 32'h1);
  endtask

  task automatic t_readonly;
    wr(5'h00, 32'hffff_ffff, 3'd4);
    wr(5'h04, 32'h0, 3'd4);
    wr(5'h0C, 32'h0, 3'd4);
    chk_rd("R2 up", 5'h00, 32'h88);
    chk_rd("R2 down", 5'h04, 32'h88);
    chk_rd("R2 rmv", 5'h0C, 32'hffff_ffdf);
  endtask

  task automatic t_badacc;
    logic [31:0] v;
    wr(5'h08, 32'h08, 3'd2);
    wr(5'h09, 32'h08, 3'd4);
    chk_rd("R13 down after bad writes", 5'h04, 32'h88);
    rd(5'h04, 3'd1, v);
    chk("R13 short read", v, 32'h0);
  endtask

  task automatic t_zero;
    @(negedge clk);
    io_wr = 1'b1; io_addr = 5'h08; io_wdata = 32'h0;
    @(negedge clk);
    io_wr = 1'b0;
    chk("R11 no pulse", eject_done, 32'h0);
    chk_rd("R11 down kept", 5'h04, 32'h88);
    chk_rd("R11 up kept", 5'h00, 32'h88);
  endtask

  task automatic t_eject;
    @(negedge clk);
    io_wr = 1'b1; io_addr = 5'h08; io_wdata = 32'h88;
    @(negedge clk);
    io_wr = 1'b0;
    chk("R4 lowest slot pulse", eject_done, 32'h08);
    chk_rd("R4 down", 5'h04, 32'h80);
    chk_rd("R5 hotpluggable presence cleared", 5'h00, 32'h80);
    @(negedge clk);
    chk("R4 pulse one cycle", eject_done, 32'h0);
    wr(5'h08, 32'h80, 3'd4);
    chk_rd("R4 down empty", 5'h04, 32'h0);
    chk_rd("R5 up empty", 5'h00, 32'h0);
  endtask

  task automatic t_fixed;
    strobe('0, 32'h400, '0);
    strobe('0, '0, 32'h400);
    chk_rd("R7 down fixed slot", 5'h04, 32'h400);
    wr(5'h08, 32'h400, 3'd4);
    chk_rd("R5 fixed presence kept", 5'h00, 32'h400);
    chk_rd("R5 down cleared", 5'h04, 32'h0);
  endtask

  task automatic t_collide;
    strobe('0, 32'h1000, 32'h1000);
    @(negedge clk);
    io_wr = 1'b1; io_addr = 5'h08; io_wdata = 32'h1000;
    hot_add = 32'h1000; hot_rm = 32'h1000;
    @(negedge clk);
    io_wr = 1'b0; hot_add = '0; hot_rm = '0;
    chk("R12 pulse", eject_done, 32'h1000);
    chk_rd("R12 down kept", 5'h04, 32'h1000);
    chk_rd("R12 presence kept", 5'h00, 32'h1400);
  endtask

  task automatic t_drain;
    strobe('0, '0, 32'h2);
    chk_rd("R10 setup down", 5'h04, 32'h1002);
    @(negedge clk);
    plat_rst = 1'b1;
    @(negedge clk);
    plat_rst = 1'b0;
    chk("R10 no pulse at start", eject_done, 32'h0);
    hot_add = 32'h0010_0000;
    @(negedge clk);
    hot_add = '0;
    chk("R10 first drained slot", eject_done, 32'h2);
    chk_rd("R10 down after first", 5'h04, 32'h1000);
    @(negedge clk);
    chk("R10 second drained slot", eject_done, 32'h1000);
    chk_rd("R10 down empty", 5'h04, 32'h0);
    @(negedge clk);
    chk("R10 pulses over", eject_done, 32'h0);
    chk_rd("R10 rebuilt up", 5'h00, 32'h1);
    chk_rd("R10 rebuilt rmv", 5'h0C, 32'hffff_fbdf);
    chk("R10 evt untouched", 32'(evt_sts), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold();
    t_hot();
    t_readonly();
    t_badacc();
    t_zero();
    t_eject();
    t_fixed();
    t_collide();
    t_drain();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule